// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a row of boundary scan cells that sits between a device's pins and its core logic. Each cell holds two storage bits. The first is a capture/shift stage, which either samples the pin value or passes serial data along the row. The second is an update stage, which holds the value that test mode drives toward the core. Serial data enters at the far end of the row, at cell `N_CELLS-1`, and leaves at cell 0.

All storage runs on the test clock `tck`. The data-register clock strobe acts as a per-cycle enable. The update strobe is watched for its falling transition, and that transition copies the shift stage into the update stage. Because the two stages are separate, a scan can shift new data in (preload) or shift sampled pin values out (sample) while the outputs toward the core stay unchanged. The test-select input chooses what the core sees: the live pins, or the held update stage.

Top module: `bscan_chain`

## Requirements
- R1: An active-low `rst_n` clears every shift stage and every update stage to 0. After reset, `ser_out` is 0, and with `test_sel`=1 all of `sys_out` is 0.
- R2: While `test_sel`=0, `sys_out` equals `sys_in` in the same cycle, with no clock involved.
- R3: At a `tck` edge with `dr_clk_en`=1 and `shift_en`=0, cell i's shift stage loads `sys_in[i]`. The captured word then leaves on `ser_out` bit 0 first.
- R4: At a `tck` edge with `dr_clk_en`=1 and `shift_en`=1, cell i takes the old value of cell i+1, and cell `N_CELLS-1` takes `ser_in`. `ser_out` always shows cell 0's shift stage. The first bit shifted in therefore reaches `ser_out` after `N_CELLS` shifts.
- R5: At a `tck` edge with `dr_clk_en`=0, no shift stage changes, whatever `shift_en`, `ser_in` and `sys_in` are.
- R6: When `dr_update` is sampled 1 at one `tck` edge and 0 at the next, every update stage loads its shift stage at that second edge. While `test_sel`=1, `sys_out` shows the update stages.
- R7: Shifting and capturing never change the update stages, so `sys_out` stays constant during a scan while `test_sel`=1.
- R8: Holding `dr_update` at 1, or its rising transition, does not load the update stages.
- R9: If an update transition and a capture or shift fall on the same edge, the update stage receives the shift-stage value from before that edge.
- R10: With `test_sel`=0, loading the update stages does not disturb `sys_out`. The preloaded word appears only once `test_sel` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all storage updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of all cells |
| sys_in | input | N_CELLS | Values arriving from the device pins |
| sys_out | output | N_CELLS | Values presented to the core logic |
| ser_in | input | 1 | Serial data entering cell N_CELLS-1 |
| ser_out | output | 1 | Serial data leaving cell 0 |
| shift_en | input | 1 | 1 selects shift, 0 selects capture for the shift stage |
| dr_clk_en | input | 1 | Enables the shift stage for this edge |
| dr_update | input | 1 | Update strobe; its falling transition loads the update stages |
| test_sel | input | 1 | 1 drives sys_out from the update stages, 0 passes sys_in |

## Verification
The update transition and a capture or shift can occur on the same edge. In that case the update stage must receive the shift-stage contents from before the edge, not the newly captured or shifted bits. The bench provokes this in two ways. It drops `dr_update` in the same cycle as a capture, both in the table and in a directed case with known words. It also drops `dr_update` in the middle of a shift sequence. It judges the result from `sys_out` with `test_sel`=1, which must show the pre-edge word, while `ser_out` shows the newly captured bit.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   // Operation applied to every shift stage at the next tck edge.
   typedef enum logic [1:0] {
      QA_HOLD    = 2'd0,
      QA_CAPTURE = 2'd1,
      QA_SHIFT   = 2'd2
   } qa_op_e;

   function automatic qa_op_e decode_qa_op(input logic clk_en, input logic shift);
      if (!clk_en)
         return QA_HOLD;
      return shift ? QA_SHIFT : QA_CAPTURE;
   endfunction

endpackage

// File: rtl/bsc_upd_edge.sv
module bsc_upd_edge #(
   parameter bit FALL_EDGE = 1'b1
) (
   input  logic tck,
   input  logic rst_n,
   input  logic strobe,
   output logic fire
);
   logic strobe_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)
         strobe_q <= 1'b0;
      else
         strobe_q <= strobe;
   end

   generate
      if (FALL_EDGE) begin : g_fall
         assign fire = strobe_q & ~strobe;
      end else begin : g_rise
         assign fire = ~strobe_q & strobe;
      end
   endgenerate

endmodule

// File: rtl/bsc_cell.sv
module bsc_cell
   import bsc_pkg::*;
(
   input  logic   tck,
   input  logic   rst_n,
   input  qa_op_e op,
   input  logic   upd_fire,
   input  logic   test_sel,
   input  logic   pin_i,
   input  logic   ser_i,
   output logic   qa_o,
   output logic   qb_o,
   output logic   pin_o
);
   logic qa_q;
   logic qb_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         qa_q <= 1'b0;
      end else begin
         unique case (op)
            QA_CAPTURE: qa_q <= pin_i;
            QA_SHIFT:   qa_q <= ser_i;
            default:    qa_q <= qa_q;
         endcase
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)
         qb_q <= 1'b0;
      else if (upd_fire)
         qb_q <= qa_q;
   end

   assign qa_o  = qa_q;
   assign qb_o  = qb_q;
   assign pin_o = test_sel ? qb_q : pin_i;

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
   import bsc_pkg::*;
#(
   parameter int N_CELLS        = 12,
   parameter bit UPDATE_ON_FALL = 1'b1
) (
   input  logic               tck,
   input  logic               rst_n,
   input  logic [N_CELLS-1:0] sys_in,
   output logic [N_CELLS-1:0] sys_out,
   input  logic               ser_in,
   output logic               ser_out,
   input  logic               shift_en,
   input  logic               dr_clk_en,
   input  logic               dr_update,
   input  logic               test_sel
);
   localparam int LINK_W = N_CELLS + 1;

   generate
      if (N_CELLS < 2) begin : g_bad_len
         $error("bscan_chain: N_CELLS must be at least 2");
      end
   endgenerate

   qa_op_e              qa_op;
   logic                upd_fire;
   logic [LINK_W-1:0]   link;
   logic [N_CELLS-1:0]  qa_vec;
   logic [N_CELLS-1:0]  qb_vec;

   assign qa_op = decode_qa_op(dr_clk_en, shift_en);

   bsc_upd_edge #(.FALL_EDGE(UPDATE_ON_FALL)) u_upd_edge (
      .tck    (tck),
      .rst_n  (rst_n),
      .strobe (dr_update),
      .fire   (upd_fire)
   );

   assign link[N_CELLS] = ser_in;

   generate
      for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
         bsc_cell u_cell (
            .tck      (tck),
            .rst_n    (rst_n),
            .op       (qa_op),
            .upd_fire (upd_fire),
            .test_sel (test_sel),
            .pin_i    (sys_in[i]),
            .ser_i    (link[i+1]),
            .qa_o     (link[i]),
            .qb_o     (qb_vec[i]),
            .pin_o    (sys_out[i])
         );
      end
   endgenerate

   assign qa_vec  = link[N_CELLS-1:0];
   assign ser_out = link[0];

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
   parameter int N_CELLS = 12
) (
   input logic               tck,
   input logic               rst_n,
   input logic [N_CELLS-1:0] sys_in,
   input logic [N_CELLS-1:0] sys_out,
   input logic               ser_in,
   input logic               shift_en,
   input logic               dr_clk_en,
   input logic               dr_update,
   input logic               test_sel,
   input logic [N_CELLS-1:0] qa_vec,
   input logic [N_CELLS-1:0] qb_vec
);

   p_pass_through_r2: assert property (@(posedge tck) disable iff (!rst_n)
      !test_sel |-> sys_out == sys_in);

   p_capture_r3: assert property (@(posedge tck) disable iff (!rst_n)
      (dr_clk_en && !shift_en) |=> qa_vec == $past(sys_in));

   p_shift_r4: assert property (@(posedge tck) disable iff (!rst_n)
      (dr_clk_en && shift_en) |=> qa_vec == {$past(ser_in), $past(qa_vec[N_CELLS-1:1])});

   p_hold_r5: assert property (@(posedge tck) disable iff (!rst_n)
      !dr_clk_en |=> $stable(qa_vec));

   p_test_out_r6: assert property (@(posedge tck) disable iff (!rst_n)
      test_sel |-> sys_out == qb_vec);

   // R8 and R7: no falling update strobe means the update stages keep their value
   p_no_update_r8: assert property (@(posedge tck) disable iff (!rst_n)
      (dr_update || !$past(dr_update)) |=> $stable(qb_vec));

   // R9: update takes the shift-stage value from before the edge
   p_update_old_r9: assert property (@(posedge tck) disable iff (!rst_n)
      ($past(dr_update) && !dr_update) |=> qb_vec == $past(qa_vec));

endmodule

bind bscan_chain bscan_chain_chk #(.N_CELLS(N_CELLS)) u_chk (
   .tck       (tck),
   .rst_n     (rst_n),
   .sys_in    (sys_in),
   .sys_out   (sys_out),
   .ser_in    (ser_in),
   .shift_en  (shift_en),
   .dr_clk_en (dr_clk_en),
   .dr_update (dr_update),
   .test_sel  (test_sel),
   .qa_vec    (qa_vec),
   .qb_vec    (qb_vec)
);

// File: tb/bscan_chain_tb_top.sv
`timescale 1ns/1ps
module bscan_chain_tb_top;
   localparam int N = 12;
   localparam int NV = 16;
   localparam int WATCHDOG = 100000;

   // vector: {shift_en, dr_clk_en, dr_update, test_sel, ser_in, sys_in[11:0]}
   localparam logic [N+4:0] VEC [NV] = '{
      {5'b01010, 12'h3C5}, {5'b11001, 12'h000}, {5'b11000, 12'h111}, {5'b11101, 12'h222},
      {5'b11000, 12'h333}, {5'b00010, 12'hFFF}, {5'b01100, 12'h5A5}, {5'b01000, 12'h0F0},
      {5'b00010, 12'h123}, {5'b10011, 12'h456}, {5'b11011, 12'h789}, {5'b00100, 12'hBCD},
      {5'b00000, 12'hE01}, {5'b01110, 12'hABC}, {5'b01010, 12'h777}, {5'b11011, 12'h000}
   };

   logic         tck = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] sys_in = '0;
   logic [N-1:0] sys_out;
   logic         ser_in = 1'b0;
   logic         ser_out;
   logic         shift_en = 1'b0;
   logic         dr_clk_en = 1'b0;
   logic         dr_update = 1'b0;
   logic         test_sel = 1'b1;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // independent reference state built from the requirements
   logic [N-1:0] m_qa = '0;
   logic [N-1:0] m_qb = '0;
   logic         m_upd_q = 1'b0;

   always #4 tck = ~tck;

   bscan_chain #(.N_CELLS(N)) dut_i (
      .tck(tck), .rst_n(rst_n), .sys_in(sys_in), .sys_out(sys_out),
      .ser_in(ser_in), .ser_out(ser_out), .shift_en(shift_en),
      .dr_clk_en(dr_clk_en), .dr_update(dr_update), .test_sel(test_sel)
   );

   always @(posedge tck) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WATCHDOG);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // drive at a negedge, model the rising edge, compare at the next negedge
   task automatic step(input logic sh, input logic ce, input logic up, input logic ts,
                       input logic si, input logic [N-1:0] d);
      shift_en = sh; dr_clk_en = ce; dr_update = up; test_sel = ts; ser_in = si; sys_in = d;
      @(posedge tck);
      if (m_upd_q && !up) m_qb = m_qa;
      if (ce) m_qa = sh ? {si, m_qa[N-1:1]} : d;
      m_upd_q = up;
      @(negedge tck);
      chk("R4 ser_out model", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, m_qa[0]});
      chk("R6 sys_out model", sys_out, ts ? m_qb : d);
   endtask

   initial begin
      logic [N-1:0] pat;
      logic         held;
      repeat (3) @(negedge tck);
      rst_n = 1'b1;
      @(negedge tck);
      chk("R1 ser_out after reset", {{(N-1){1'b0}}, ser_out}, '0);
      chk("R1 sys_out after reset", sys_out, '0);

      // R2: pass-through without any clock edge
      test_sel = 1'b0;
      sys_in = 12'hA3F; #1 chk("R2 pass-through", sys_out, 12'hA3F);
      sys_in = 12'h05C; #1 chk("R2 pass-through", sys_out, 12'h05C);
      @(negedge tck);

      // table walk
      for (int v = 0; v < NV; v++)
         step(VEC[v][N+4], VEC[v][N+3], VEC[v][N+2], VEC[v][N+1], VEC[v][N], VEC[v][N-1:0]);
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);

      // R3 and R4: capture a word and shift it out bit 0 first
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'hA5C);
      for (int i = 0; i < N; i++) begin
         chk("R3 captured bit", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, pat_bit(12'hA5C, i)});
         step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000);
      end

      // R4 and R6: preload a pattern, then strobe the update
      pat = 12'h9B4;
      for (int i = 0; i < N; i++) step(1'b1, 1'b1, 1'b0, 1'b1, pat[i], 12'hFFF);
      chk("R4 first bit reaches ser_out", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, pat[0]});
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12'h000);
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12'h000);
      chk("R8 held strobe no load", sys_out, m_qb);
      chk("R8 held strobe no load", sys_out === pat ? 12'h001 : 12'h000, 12'h000);
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000);
      chk("R6 update on fall", sys_out, pat);

      // R7: scanning does not move sys_out
      for (int i = 0; i < N; i++) begin
         step(1'b1, 1'b1, 1'b0, 1'b1, i[0], 12'h555);
         chk("R7 sys_out stable in scan", sys_out, pat);
      end
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'hC3C);
      chk("R7 sys_out stable in capture", sys_out, pat);

      // R5: shift requested without the clock enable
      held = ser_out;
      for (int i = 0; i < 4; i++) begin
         step(1'b1, 1'b0, 1'b0, 1'b1, ~held, 12'h000);
         chk("R5 hold without enable", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, held});
      end

      // R9: update fall and capture on the same edge
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h1E1);
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12'h000);
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h6D2);
      chk("R9 update gets pre-edge word", sys_out, 12'h1E1);
      chk("R9 capture still lands", {{(N-1){1'b0}}, ser_out}, '0);

      // R10: preload under pass-through
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'h0AA);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h0AB);
      chk("R10 pass-through during update", sys_out, 12'h0AB);
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h0AB);
      chk("R10 preload appears in test", sys_out, 12'h6D2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   function automatic logic pat_bit(input logic [N-1:0] w, input int i);
      return w[i];
   endfunction

endmodule